// File: doc/BRIEF.md
# Slave-Port Bus Arbiter

This block decides which of six bus masters owns one slave port of a multi-layer interconnect. Each master drives a request line and has a fixed index 0 to 5; a configuration bit picks rotating (round-robin) or priority-ordered selection, and each master carries a 2-bit priority value used in the priority-ordered mode. The arbiter drives a one-hot grant vector and a flag telling whether the slave is connected to any master at all.

Ownership only changes at a transfer boundary: the current owner keeps the port until the slave side pulses `xfer_done`. When a transfer ends and nobody else is waiting, a 2-bit parking policy decides whether the port goes idle (saves power, costs one cycle on the next first access), stays with the master that just finished, or moves to a configured default master. A parked master that then asks for the port gets it with no added cycle.

The control is a three-state machine. `ST_DISC` (no master connected, grant all-zero), `ST_OWN` (a master owns the port and a transfer may be running) and `ST_PARK` (a master is connected but no transfer is running). Transitions: `DISC->OWN` on any request (grant appears one cycle later); `OWN->OWN` on `xfer_done` with requests pending (new winner); `OWN->PARK` or `OWN->DISC` on `xfer_done` with no requests, per the parking policy; `PARK->OWN` when the parked master requests (same owner) or when another master requests (new winner, one cycle later); `PARK->PARK` or `PARK->DISC` while idle, the parking policy being applied again every idle cycle.

Top module: `arb_slave_port`

## Requirements
- R1: After reset the grant vector is all-zero, `connected` is low and the rotation pointer is 0, so the first round-robin decision favours the lowest requesting index.
- R2: `grant` is always one-hot or all-zero, and `connected` is high exactly when `grant` is non-zero.
- R3: From the disconnected state, a request seen at a clock edge produces the grant at that edge, so the grant is visible one cycle after the request is raised (one cycle of extra latency).
- R4: With `rr_mode`=1, the winner is the first requesting master found scanning upward (with wrap) from the pointer; after each grant the pointer becomes the granted index plus one, wrapping 5 to 0.
- R5: With `rr_mode`=0, the requesting master with the largest priority value wins; master i's priority sits at `prio_cfg[2*i+1:2*i]`.
- R6: With `rr_mode`=0, among requesters sharing the largest priority value the highest index wins.
- R7: While a master is connected and `xfer_done` is low, its grant does not move, whatever other masters request.
- R8: With `park_mode` 2'b00 (2'b11 behaves the same), a transfer ending with no request pending leaves the slave disconnected on the next cycle.
- R9: With `park_mode` 2'b01, a transfer ending with no request pending keeps the grant on the master that just finished.
- R10: With `park_mode` 2'b10, an idle slave is handed to master `dflt_id`; if `dflt_id` is 6 or 7 the slave goes disconnected instead. The policy is re-applied on every idle cycle while parked.
- R11: A parked master that raises its request keeps its grant with no gap; a different master requesting a parked slave (parked master not requesting) receives the grant one cycle later.
- R12: On a cycle with `xfer_done` high, a new winner is chosen among all current requests, including the current owner.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req | input | 6 | Request line per master, bit i for master i |
| prio_cfg | input | 12 | 2-bit priority per master, master i at bits 2i+1:2i |
| rr_mode | input | 1 | 1 selects round-robin, 0 selects fixed priority |
| park_mode | input | 2 | 00/11 disconnect, 01 keep last master, 10 park on default master |
| dflt_id | input | 3 | Index of the default master for park mode 10 |
| xfer_done | input | 1 | High on the last cycle of the current owner's transfer |
| grant | output | 6 | One-hot grant, bit i for master i |
| connected | output | 1 | High when some master is connected to the slave |

## Verification
The bench targets the pointer wrap from index 5 back to 0, a priority tie between two top-priority masters (an arbiter breaking it toward the lower index would hand the port to master 0 instead of 4), and a higher-priority newcomer arriving mid-transfer, where a design that re-arbitrates without `xfer_done` would yank the grant from the owner. It also covers a parked master re-requesting (a wrong design would drop the grant for a cycle or hand it elsewhere), the out-of-range default index (which must disconnect rather than grant a nonexistent master), and park code 11 treated as disconnect. A long seeded random run with changing modes compares every cycle against a bench model of the rules.

// File: rtl/arb_pkg.sv
package arb_pkg;

    // Controller states
    typedef enum logic [1:0] {
        ST_DISC = 2'd0,   // slave connected to nobody
        ST_OWN  = 2'd1,   // a master owns the slave, transfer may run
        ST_PARK = 2'd2    // a master is connected, no transfer running
    } arb_state_e;

    // Parking policy codes
    localparam logic [1:0] PARK_NONE  = 2'b00;
    localparam logic [1:0] PARK_LAST  = 2'b01;
    localparam logic [1:0] PARK_FIXED = 2'b10;

endpackage

// File: rtl/arb_rr_pick.sv
module arb_rr_pick #(
    parameter int unsigned NUM_MASTERS = 6,
    localparam int unsigned IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic [NUM_MASTERS-1:0] req,
    input  logic [IDX_W-1:0]       ptr,
    output logic                   hit,
    output logic [IDX_W-1:0]       idx
);

    // Scan from the largest offset down so the smallest offset wins.
    always_comb begin
        hit = 1'b0;
        idx = '0;
        for (int off = NUM_MASTERS - 1; off >= 0; off--) begin
            if (req[(int'(ptr) + off) % NUM_MASTERS]) begin
                hit = 1'b1;
                idx = IDX_W'((int'(ptr) + off) % NUM_MASTERS);
            end
        end
    end

endmodule

// File: rtl/arb_prio_pick.sv
module arb_prio_pick #(
    parameter int unsigned NUM_MASTERS = 6,
    parameter int unsigned PRIO_W      = 2,
    localparam int unsigned IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic [NUM_MASTERS-1:0]        req,
    input  logic [NUM_MASTERS*PRIO_W-1:0] prio,
    output logic                          hit,
    output logic [IDX_W-1:0]              idx
);

    logic [PRIO_W-1:0] best;

    // Ascending scan with >= : equal values move the pick to higher index.
    always_comb begin
        hit  = 1'b0;
        idx  = '0;
        best = '0;
        for (int i = 0; i < NUM_MASTERS; i++) begin
            if (req[i] && (!hit || prio[i*PRIO_W +: PRIO_W] >= best)) begin
                hit  = 1'b1;
                best = prio[i*PRIO_W +: PRIO_W];
                idx  = IDX_W'(i);
            end
        end
    end

endmodule

// File: rtl/arb_slave_port.sv
module arb_slave_port
    import arb_pkg::*;
#(
    parameter int unsigned NUM_MASTERS = 6,
    parameter int unsigned PRIO_W      = 2,
    localparam int unsigned IDX_W = $clog2(NUM_MASTERS)
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic [NUM_MASTERS-1:0]        req,
    input  logic [NUM_MASTERS*PRIO_W-1:0] prio_cfg,
    input  logic                          rr_mode,
    input  logic [1:0]                    park_mode,
    input  logic [IDX_W-1:0]              dflt_id,
    input  logic                          xfer_done,
    output logic [NUM_MASTERS-1:0]        grant,
    output logic                          connected
);

    arb_state_e             state_q, state_d;
    logic [IDX_W-1:0]       owner_q, owner_d;
    logic [IDX_W-1:0]       ptr_q, ptr_d;

    logic                   rr_hit, fp_hit, any_req;
    logic [IDX_W-1:0]       rr_idx, fp_idx, win_idx;

    arb_state_e             park_st;
    logic [IDX_W-1:0]       park_own;
    logic [NUM_MASTERS-1:0] owner_oh;

    function automatic logic [IDX_W-1:0] wrap_inc(input logic [IDX_W-1:0] v);
        if (32'(v) >= NUM_MASTERS - 1)
            return '0;
        return v + 1'b1;
    endfunction

    // ---------------- selection logic ----------------
    arb_rr_pick #(
        .NUM_MASTERS(NUM_MASTERS)
    ) u_rr (
        .req(req),
        .ptr(ptr_q),
        .hit(rr_hit),
        .idx(rr_idx)
    );

    arb_prio_pick #(
        .NUM_MASTERS(NUM_MASTERS),
        .PRIO_W     (PRIO_W)
    ) u_fp (
        .req (req),
        .prio(prio_cfg),
        .hit (fp_hit),
        .idx (fp_idx)
    );

    assign any_req = rr_mode ? rr_hit : fp_hit;
    assign win_idx = rr_mode ? rr_idx : fp_idx;

    // ---------------- parking decision ----------------
    always_comb begin
        park_st  = ST_DISC;
        park_own = owner_q;
        unique case (park_mode)
            PARK_LAST: begin
                park_st  = ST_PARK;
                park_own = owner_q;
            end
            PARK_FIXED: begin
                if (32'(dflt_id) < NUM_MASTERS) begin
                    park_st  = ST_PARK;
                    park_own = dflt_id;
                end
            end
            default: begin
                park_st  = ST_DISC;
                park_own = owner_q;
            end
        endcase
    end

    // ---------------- next-state logic ----------------
    always_comb begin
        state_d = state_q;
        owner_d = owner_q;
        ptr_d   = ptr_q;
        unique case (state_q)
            ST_DISC: begin
                if (any_req) begin
                    state_d = ST_OWN;
                    owner_d = win_idx;
                    ptr_d   = wrap_inc(win_idx);
                end
            end
            ST_OWN: begin
                if (xfer_done) begin
                    if (any_req) begin
                        owner_d = win_idx;
                        ptr_d   = wrap_inc(win_idx);
                    end else begin
                        state_d = park_st;
                        owner_d = park_own;
                    end
                end
            end
            ST_PARK: begin
                if (req[owner_q]) begin
                    state_d = ST_OWN;
                    ptr_d   = wrap_inc(owner_q);
                end else if (any_req) begin
                    state_d = ST_OWN;
                    owner_d = win_idx;
                    ptr_d   = wrap_inc(win_idx);
                end else begin
                    state_d = park_st;
                    owner_d = park_own;
                end
            end
            default: begin
                state_d = ST_DISC;
            end
        endcase
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_DISC;
            owner_q <= '0;
            ptr_q   <= '0;
        end else begin
            state_q <= state_d;
            owner_q <= owner_d;
            ptr_q   <= ptr_d;
        end
    end

    // ---------------- outputs ----------------
    for (genvar g = 0; g < NUM_MASTERS; g++) begin : g_oh
        assign owner_oh[g] = (32'(owner_q) == g);
    end

    always_comb begin
        grant     = '0;
        connected = 1'b0;
        unique case (state_q)
            ST_OWN, ST_PARK: begin
                grant     = owner_oh;
                connected = 1'b1;
            end
            default: begin
                grant     = '0;
                connected = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/arb_slave_port_chk.sv
module arb_slave_port_chk #(
    parameter int unsigned NUM_MASTERS = 6,
    localparam int unsigned IDX_W = $clog2(NUM_MASTERS)
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [NUM_MASTERS-1:0] req,
    input logic [1:0]             park_mode,
    input logic [IDX_W-1:0]       dflt_id,
    input logic                   xfer_done,
    input logic [NUM_MASTERS-1:0] grant,
    input logic                   connected
);

    // R2
    grant_onehot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R2
    conn_match_chk: assert property (@(posedge clk) disable iff (!rst_n)
        connected == (grant != '0));

    // R3
    first_access_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!connected && req != '0) |=> connected);

    // R7
    owner_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (connected && !xfer_done && (grant & req) != '0) |=> $stable(grant));

    // R8
    park_none_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (connected && xfer_done && req == '0 &&
         (park_mode == 2'b00 || park_mode == 2'b11)) |=> !connected);

    // R9
    park_last_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (connected && xfer_done && req == '0 && park_mode == 2'b01)
        |=> (connected && $stable(grant)));

    // R10
    park_fixed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (connected && xfer_done && req == '0 && park_mode == 2'b10 &&
         32'(dflt_id) < NUM_MASTERS)
        |=> grant == (NUM_MASTERS'(1) << $past(dflt_id)));

endmodule

bind arb_slave_port arb_slave_port_chk #(
    .NUM_MASTERS(NUM_MASTERS)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .req      (req),
    .park_mode(park_mode),
    .dflt_id  (dflt_id),
    .xfer_done(xfer_done),
    .grant    (grant),
    .connected(connected)
);

// File: tb/sim_arb_slave_port.sv
`timescale 1ns/1ps
module sim_arb_slave_port;

    localparam int N  = 6;
    localparam int PW = 2;
    localparam int IW = 3;

    logic            clk = 1'b0;
    logic            rst_n;
    logic [N-1:0]    req;
    logic [N*PW-1:0] prio_cfg;
    logic            rr_mode;
    logic [1:0]      park_mode;
    logic [IW-1:0]   dflt_id;
    logic            xfer_done;
    logic [N-1:0]    grant;
    logic            connected;

    always #2 clk = ~clk;

    arb_slave_port #(.NUM_MASTERS(N), .PRIO_W(PW)) u0 (
        .clk(clk), .rst_n(rst_n), .req(req), .prio_cfg(prio_cfg),
        .rr_mode(rr_mode), .park_mode(park_mode), .dflt_id(dflt_id),
        .xfer_done(xfer_done), .grant(grant), .connected(connected)
    );

    int checks = 0;
    int fails  = 0;

    // reference model state
    bit m_conn, m_busy;
    int m_owner, m_ptr;

    function automatic int m_pick(input logic [N-1:0] r, input bit rr,
                                  input logic [N*PW-1:0] p, input int ptr);
        int best, bi;
        if (rr) begin
            for (int off = 0; off < N; off++)
                if (r[(ptr + off) % N]) return (ptr + off) % N;
            return -1;
        end
        best = -1; bi = -1;
        for (int i = 0; i < N; i++)
            if (r[i] && int'(p[i*PW +: PW]) >= best) begin
                best = int'(p[i*PW +: PW]);
                bi = i;
            end
        return bi;
    endfunction

    task automatic m_park();
        if (park_mode == 2'b01) m_busy = 0;
        else if (park_mode == 2'b10 && int'(dflt_id) < N) begin
            m_busy = 0; m_owner = int'(dflt_id);
        end else m_conn = 0;
    endtask

    task automatic m_take(input int w);
        m_conn = 1; m_busy = 1; m_owner = w; m_ptr = (w + 1) % N;
    endtask

    task automatic m_step();
        int w;
        w = m_pick(req, rr_mode, prio_cfg, m_ptr);
        if (!m_conn) begin
            if (w >= 0) m_take(w);
        end else if (m_busy) begin
            if (xfer_done) begin
                if (w >= 0) m_take(w); else m_park();
            end
        end else begin
            if (req[m_owner]) m_take(m_owner);
            else if (w >= 0) m_take(w);
            else m_park();
        end
    endtask

    task automatic m_reset();
        m_conn = 0; m_busy = 0; m_owner = 0; m_ptr = 0;
    endtask

    function automatic logic [N-1:0] m_grant();
        return m_conn ? N'(1 << m_owner) : '0;
    endfunction

    task automatic chk(input string tag, input logic [N-1:0] eg, input bit ec);
        checks++;
        if (grant !== eg || connected !== ec) begin
            fails++;
            $display("FAIL %s: grant=%b connected=%b expected grant=%b connected=%b",
                     tag, grant, connected, eg, ec);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic do_reset();
        rst_n = 1'b0;
        repeat (3) tick();
        rst_n = 1'b1;
        m_reset();
    endtask

    initial begin
        void'($urandom(32'd4711));
        rst_n = 1'b0; req = '0; prio_cfg = '0; rr_mode = 1'b1;
        park_mode = 2'b00; dflt_id = '0; xfer_done = 1'b0;
        @(negedge clk);
        do_reset();
        chk("R1 reset state", 6'b000000, 0);

        // ---- round-robin, no parking ----
        rr_mode = 1; park_mode = 2'b00;
        req = 6'b101100; xfer_done = 0;
        chk("R3 no grant before edge", 6'b000000, 0);
        tick(); chk("R1 R3 R4 lowest index first", 6'b000100, 1);
        tick(); chk("R7 hold without done", 6'b000100, 1);
        xfer_done = 1;
        tick(); chk("R12 rotate to 3", 6'b001000, 1);
        tick(); chk("R4 rotate to 5", 6'b100000, 1);
        tick(); chk("R4 wrap to 2", 6'b000100, 1);
        req = '0;
        tick(); chk("R8 disconnect", 6'b000000, 0);

        // ---- fixed priority, park on last ----
        rr_mode = 0; park_mode = 2'b01; xfer_done = 0;
        prio_cfg = 12'b10_11_00_00_01_11;   // m5=2 m4=3 m1=1 m0=3
        req = 6'b100011;
        tick(); chk("R5 highest priority", 6'b000001, 1);
        req = 6'b110011; xfer_done = 1;
        tick(); chk("R6 tie to higher index", 6'b010000, 1);
        req = '0;
        tick(); chk("R9 stay with last", 6'b010000, 1);
        req = 6'b010000; xfer_done = 0;
        chk("R11 parked grant present", 6'b010000, 1);
        tick(); chk("R11 no gap", 6'b010000, 1);
        req = '0; xfer_done = 1;
        tick(); chk("R9 park again", 6'b010000, 1);
        req = 6'b000010; xfer_done = 0;
        chk("R11 other master waits", 6'b010000, 1);
        tick(); chk("R11 other master one cycle", 6'b000010, 1);

        // ---- fixed default parking ----
        rr_mode = 1; park_mode = 2'b10; dflt_id = 3'd3;
        req = '0; xfer_done = 1;
        tick(); chk("R10 park on default", 6'b001000, 1);
        dflt_id = 3'd7; xfer_done = 0;
        tick(); chk("R10 invalid default disconnects", 6'b000000, 0);

        // ---- owner holds against higher priority ----
        rr_mode = 0; park_mode = 2'b11; req = 6'b000010;
        tick(); chk("R5 single requester", 6'b000010, 1);
        req = 6'b000011; xfer_done = 0;
        tick(); chk("R7 no preemption", 6'b000010, 1);
        xfer_done = 1;
        tick(); chk("R12 higher priority after done", 6'b000001, 1);
        req = '0;
        tick(); chk("R8 code 11 disconnects", 6'b000000, 0);

        // ---- seeded random against model ----
        xfer_done = 0;
        do_reset();
        chk("R1 reset again", 6'b000000, 0);
        for (int i = 0; i < 3000; i++) begin
            if (i % 97 == 0) begin
                rr_mode   = 1'($urandom);
                park_mode = 2'($urandom);
                dflt_id   = 3'($urandom);
                prio_cfg  = 12'($urandom);
            end
            req       = ($urandom % 4 == 0) ? '0 : N'($urandom & $urandom);
            xfer_done = ($urandom % 3 == 0);
            m_step();
            tick();
            chk("R2 R4 R5 R12 random", m_grant(), m_conn);
        end

        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule